// File: doc/BRIEF.md
# Multi-Stage Thermal Protection Comparator

This block turns up to four raw temperature measurements into a three-level over-temperature alarm. Each measurement word carries a 16-bit raw code and a valid flag. Raw codes fall as the die heats, so a smaller code means a hotter sensor. A control register picks how the codes are merged into one value: their floor average, the hottest one (the smallest code), or one sensor chosen by index. The merged value is checked against three programmable 15-bit thresholds, one per protection stage. Any stage whose threshold is met sets a sticky status bit. A per-stage enable decides whether that bit drives the interrupt output.

A two-state sequencer paces the evaluation. In `S_SAMPLE` it latches the merged code and its validity, then takes the *sample-done* transition to `S_JUDGE`. In `S_JUDGE` it compares the latched code against the thresholds and merges any hits into the status register, then takes the *judge-done* transition back to `S_SAMPLE`. A change on the inputs is therefore reflected in the status within four clock cycles. Software reaches the block through a single-cycle register write port and a combinational read port.

Top module: `therm_guard`

## Requirements
- R1: After reset every register reads zero and the interrupt is low. The register map is: address 0 control (merge rule in bits 17:16, sensor index in bits 19:18), 1/2/3 stage 1/2/3 thresholds (bits 14:0), 4 interrupt enables, 5 status. Unlisted bits read zero.
- R2: Merge rule 00 uses the floor of the sum of the four raw codes divided by four. All four valid flags must be set.
- R3: Merge rule 01 uses the smallest of the four raw codes (the hottest sensor). All four valid flags must be set.
- R4: Merge rule 10 uses the code of the sensor whose index is in control bits 19:18. Only that sensor's valid flag matters.
- R5: Merge rule 11 behaves exactly like rule 00.
- R6: Stage n trips when the merged code, compared unsigned, is at or below threshold n zero-extended from 15 bits. Stages 1, 2 and 3 report on status bits 29, 30 and 31. Threshold registers keep only bits 14:0.
- R7: A status bit stays set after the condition that set it has gone away.
- R8: Writing the status register clears each bit written as one and leaves bits written as zero. Writing back the value just read clears everything that was read as set.
- R9: No status bit is set while a valid flag required by the current merge rule is low.
- R10: The interrupt output is high exactly when some status bit is set and its enable is set. The enables sit in bits 29, 30 and 31 of the enable register, at the same positions as the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| meas_i | input | 68 | Four measurement words of 17 bits each; sensor k sits at bits 17k+16:17k. In each word, bit 16 is the valid flag and bits 15:0 are the raw code |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Over-temperature interrupt |

## Verification
The assertions assume a few things about the inputs:
- Control register writes carry a two-bit merge rule and a sensor index that is in range.
- Measurement words change only between evaluations, and a word may be inspected even while its valid flag is low.

The sweeping stimulus respects these assumptions. It changes the sensor codes and the control word only at negative clock edges. It then allows at least one full sample-and-judge pair before clearing the status, and a second pair before reading it back. As a result, every observed status word comes from a single, stable input pattern.

// File: rtl/therm_guard_pkg.sv
package therm_guard_pkg;

    typedef enum logic [1:0] {
        MODE_AVG = 2'b00,
        MODE_MAX = 2'b01,
        MODE_ONE = 2'b10,
        MODE_RSV = 2'b11
    } comb_mode_e;

    typedef enum logic [0:0] {
        S_SAMPLE = 1'b0,
        S_JUDGE  = 1'b1
    } eval_state_e;

    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 32;
    localparam int MODE_LSB = 16;
    localparam int SEL_LSB  = 18;
    localparam int STAT_LSB = 29;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_THR1 = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_THR2 = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_THR3 = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_IEN  = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd5;

endpackage

// File: rtl/therm_combine.sv
module therm_combine
    import therm_guard_pkg::*;
#(
    parameter int NUM_SENS = 4,
    parameter int CODE_W   = 16,
    localparam int IDX_W   = $clog2(NUM_SENS),
    localparam int SUM_W   = CODE_W + IDX_W
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic [NUM_SENS*CODE_W-1:0]   codes_i,
    input  logic [NUM_SENS-1:0]          valid_i,
    input  comb_mode_e                   mode_i,
    input  logic [IDX_W-1:0]             sel_i,
    output logic [CODE_W-1:0]            comb_o,
    output logic                         ok_o
);

    logic [SUM_W-1:0]  sum;
    logic [CODE_W-1:0] hottest;
    logic [CODE_W-1:0] chosen;
    logic [CODE_W-1:0] avg;

    always_comb begin
        sum     = '0;
        hottest = codes_i[CODE_W-1:0];
        for (int k = 0; k < NUM_SENS; k++) begin
            sum = sum + SUM_W'(codes_i[k*CODE_W +: CODE_W]);
            if (codes_i[k*CODE_W +: CODE_W] < hottest) begin
                hottest = codes_i[k*CODE_W +: CODE_W];
            end
        end
        avg    = CODE_W'(sum >> IDX_W);
        chosen = codes_i[int'(sel_i)*CODE_W +: CODE_W];
    end

    always_comb begin
        unique case (mode_i)
            MODE_MAX: begin
                comb_o = hottest;
                ok_o   = &valid_i;
            end
            MODE_ONE: begin
                comb_o = chosen;
                ok_o   = valid_i[sel_i];
            end
            default: begin
                comb_o = avg;
                ok_o   = &valid_i;
            end
        endcase
    end

    // R3: in the hottest-sensor rule no input code lies below the result
    for (genvar g = 0; g < NUM_SENS; g++) begin : g_max_chk
        p_max_not_above_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (mode_i == MODE_MAX) |-> (comb_o <= codes_i[g*CODE_W +: CODE_W]));
    end

endmodule

// File: rtl/therm_ladder.sv
module therm_ladder #(
    parameter int NUM_STG = 3,
    parameter int CODE_W  = 16,
    parameter int THR_W   = 15
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [CODE_W-1:0]          comb_i,
    input  logic [NUM_STG*THR_W-1:0]   thr_i,
    output logic [NUM_STG-1:0]         hit_o
);

    localparam int PAD_W = CODE_W - THR_W;

    for (genvar g = 0; g < NUM_STG; g++) begin : g_stage
        assign hit_o[g] = comb_i <= {{PAD_W{1'b0}}, thr_i[g*THR_W +: THR_W]};
    end

    // R6: with thresholds ordered, a deeper stage hit implies the shallower one
    for (genvar g = 1; g < NUM_STG; g++) begin : g_nest_chk
        p_ladder_nested_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (hit_o[g] && (thr_i[g*THR_W +: THR_W] <= thr_i[(g-1)*THR_W +: THR_W]))
            |-> hit_o[g-1]);
    end

endmodule

// File: rtl/therm_regs.sv
module therm_regs
    import therm_guard_pkg::*;
#(
    parameter int NUM_SENS = 4,
    parameter int NUM_STG  = 3,
    parameter int THR_W    = 15,
    localparam int IDX_W   = $clog2(NUM_SENS)
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       wr_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [DATA_W-1:0]          wdata_i,
    output logic [DATA_W-1:0]          rdata_o,
    input  logic                       set_en_i,
    input  logic [NUM_STG-1:0]         hits_i,
    output comb_mode_e                 mode_o,
    output logic [IDX_W-1:0]           sel_o,
    output logic [NUM_STG*THR_W-1:0]   thr_o,
    output logic [NUM_STG-1:0]         ien_o,
    output logic [NUM_STG-1:0]         status_o
);

    comb_mode_e               mode_q;
    logic [IDX_W-1:0]         sel_q;
    logic [NUM_STG*THR_W-1:0] thr_q;
    logic [NUM_STG-1:0]       ien_q;
    logic [NUM_STG-1:0]       stat_q;
    logic [NUM_STG-1:0]       stat_d;
    logic                     stat_wr;

    assign stat_wr = wr_i && (addr_i == ADDR_STAT);

    always_comb begin
        stat_d = stat_q;
        if (stat_wr) begin
            stat_d = stat_d & ~wdata_i[STAT_LSB +: NUM_STG];
        end
        if (set_en_i) begin
            stat_d = stat_d | hits_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mode_q <= MODE_AVG;
            sel_q  <= '0;
            thr_q  <= '0;
            ien_q  <= '0;
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
            if (wr_i) begin
                unique case (addr_i)
                    ADDR_CTRL: begin
                        mode_q <= comb_mode_e'(wdata_i[MODE_LSB +: 2]);
                        sel_q  <= wdata_i[SEL_LSB +: IDX_W];
                    end
                    ADDR_THR1: thr_q[0*THR_W +: THR_W] <= wdata_i[THR_W-1:0];
                    ADDR_THR2: thr_q[1*THR_W +: THR_W] <= wdata_i[THR_W-1:0];
                    ADDR_THR3: thr_q[2*THR_W +: THR_W] <= wdata_i[THR_W-1:0];
                    ADDR_IEN:  ien_q <= wdata_i[STAT_LSB +: NUM_STG];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            ADDR_CTRL: begin
                rdata_o[MODE_LSB +: 2]   = mode_q;
                rdata_o[SEL_LSB +: IDX_W] = sel_q;
            end
            ADDR_THR1: rdata_o[THR_W-1:0] = thr_q[0*THR_W +: THR_W];
            ADDR_THR2: rdata_o[THR_W-1:0] = thr_q[1*THR_W +: THR_W];
            ADDR_THR3: rdata_o[THR_W-1:0] = thr_q[2*THR_W +: THR_W];
            ADDR_IEN:  rdata_o[STAT_LSB +: NUM_STG] = ien_q;
            ADDR_STAT: rdata_o[STAT_LSB +: NUM_STG] = stat_q;
            default: ;
        endcase
    end

    assign mode_o   = mode_q;
    assign sel_o    = sel_q;
    assign thr_o    = thr_q;
    assign ien_o    = ien_q;
    assign status_o = stat_q;

    // R7: a set status bit survives unless a one is written to it
    for (genvar g = 0; g < NUM_STG; g++) begin : g_sticky_chk
        p_status_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (stat_q[g] && !(stat_wr && wdata_i[STAT_LSB+g])) |=> stat_q[g]);
    end

endmodule

// File: rtl/therm_guard.sv
module therm_guard
    import therm_guard_pkg::*;
#(
    parameter int NUM_SENS = 4,
    parameter int CODE_W   = 16,
    parameter int THR_W    = 15,
    parameter int NUM_STG  = 3,
    localparam int MEAS_W  = CODE_W + 1,
    localparam int IDX_W   = $clog2(NUM_SENS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SENS*MEAS_W-1:0]  meas_i,
    input  logic                        reg_wr_i,
    input  logic [2:0]                  reg_addr_i,
    input  logic [31:0]                 reg_wdata_i,
    output logic [31:0]                 reg_rdata_o,
    output logic                        irq_o
);

    logic [NUM_SENS*CODE_W-1:0] codes;
    logic [NUM_SENS-1:0]        valids;

    for (genvar g = 0; g < NUM_SENS; g++) begin : g_split
        assign codes[g*CODE_W +: CODE_W] = meas_i[g*MEAS_W +: CODE_W];
        assign valids[g]                 = meas_i[g*MEAS_W + CODE_W];
    end

    comb_mode_e               mode;
    logic [IDX_W-1:0]         sel;
    logic [NUM_STG*THR_W-1:0] thr;
    logic [NUM_STG-1:0]       ien;
    logic [NUM_STG-1:0]       status;
    logic [CODE_W-1:0]        comb;
    logic                     comb_ok;
    logic [CODE_W-1:0]        comb_q;
    logic                     ok_q;
    logic [NUM_STG-1:0]       hits;

    eval_state_e state_q, state_d;
    logic        capture_en;
    logic        judge_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_SAMPLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_SAMPLE: state_d = S_JUDGE;
            S_JUDGE:  state_d = S_SAMPLE;
        endcase
    end

    always_comb begin
        capture_en = 1'b0;
        judge_en   = 1'b0;
        unique case (state_q)
            S_SAMPLE: capture_en = 1'b1;
            S_JUDGE:  judge_en   = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            comb_q <= '0;
            ok_q   <= 1'b0;
        end else if (capture_en) begin
            comb_q <= comb;
            ok_q   <= comb_ok;
        end
    end

    therm_combine #(.NUM_SENS(NUM_SENS), .CODE_W(CODE_W)) u_combine (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .codes_i (codes),
        .valid_i (valids),
        .mode_i  (mode),
        .sel_i   (sel),
        .comb_o  (comb),
        .ok_o    (comb_ok)
    );

    therm_ladder #(.NUM_STG(NUM_STG), .CODE_W(CODE_W), .THR_W(THR_W)) u_ladder (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .comb_i (comb_q),
        .thr_i  (thr),
        .hit_o  (hits)
    );

    therm_regs #(.NUM_SENS(NUM_SENS), .NUM_STG(NUM_STG), .THR_W(THR_W)) u_regs (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .wr_i     (reg_wr_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .rdata_o  (reg_rdata_o),
        .set_en_i (judge_en && ok_q),
        .hits_i   (hits),
        .mode_o   (mode),
        .sel_o    (sel),
        .thr_o    (thr),
        .ien_o    (ien),
        .status_o (status)
    );

    assign irq_o = |(status & ien);

    // R6: every sample step is followed by a judge step
    p_sample_then_judge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SAMPLE) |=> (state_q == S_JUDGE));

    // R9: judging an invalid capture adds no status bit
    p_no_set_invalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_JUDGE && !ok_q && !reg_wr_i) |=> ((status & ~$past(status)) == '0));

    // R10: an interrupt needs at least one set status bit
    p_irq_needs_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status != '0));

endmodule

// File: tb/tb_therm_guard.sv
module tb_therm_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [67:0] meas;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    logic [15:0] code [4];
    logic [3:0]  vmask;
    logic [14:0] thr [3];
    int          n_chk = 0;
    int          n_bad = 0;

    always #4 clk = ~clk;

    always_comb begin
        for (int k = 0; k < 4; k++) meas[k*17 +: 17] = {vmask[k], code[k]};
    end

    therm_guard dut (
        .clk(clk), .rst_n(rst_n), .meas_i(meas), .reg_wr_i(reg_wr),
        .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .irq_o(irq)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [2:0] model(input int mode, input int sel);
        logic [17:0] s;
        logic [15:0] mn, c;
        bit ok;
        s = '0; mn = code[0];
        for (int k = 0; k < 4; k++) begin
            s = s + 18'(code[k]);
            if (code[k] < mn) mn = code[k];
        end
        if (mode == 1) begin c = mn; ok = &vmask; end
        else if (mode == 2) begin c = code[sel]; ok = vmask[sel]; end
        else begin c = s[17:2]; ok = &vmask; end
        model[0] = ok && (c <= {1'b0, thr[0]});
        model[1] = ok && (c <= {1'b0, thr[1]});
        model[2] = ok && (c <= {1'b0, thr[2]});
    endfunction

    task automatic settle_and_clear();
        idle(4);
        wr(3'd5, 32'hE000_0000);
        idle(4);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] d;
        string tag;
        for (int k = 0; k < 4; k++) code[k] = 16'hFFFF;
        vmask = 4'h0;
        thr[0] = 15'h3000; thr[1] = 15'h2000; thr[2] = 15'h1000;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check(d == 32'h0, "R1 reset register", d, 32'h0);
        end
        check(irq == 1'b0, "R1 reset irq", {31'b0, irq}, 32'h0);

        wr(3'd1, {17'b0, thr[0]});
        wr(3'd2, {17'b0, thr[1]});
        wr(3'd3, {17'b0, thr[2]});
        wr(3'd4, 32'hE000_0000);

        // R6: threshold field is 15 bits wide
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, d);
        check(d == 32'h0000_7FFF, "R6 threshold width", d, 32'h0000_7FFF);
        wr(3'd1, {17'b0, thr[0]});

        // R2 R3 R4 R5 R6 R9 sweep
        for (int mode = 0; mode < 4; mode++) begin
            for (int sel = 0; sel < 4; sel++) begin
                wr(3'd0, (32'(mode) << 16) | (32'(sel) << 18));
                rd(3'd0, d);
                check(d == ((32'(mode) << 16) | (32'(sel) << 18)), "R1 control readback", d,
                      (32'(mode) << 16) | (32'(sel) << 18));
                for (int p = 0; p < 8; p++) begin
                    logic [2:0] e;
                    for (int k = 0; k < 4; k++) begin
                        if (p == 7) code[k] = 16'h8000 + 16'(k);
                        else code[k] = 16'((p * 16'h0900 + k * 16'h0700 + p * k * 37) & 16'hFFFF);
                    end
                    vmask = (p == 5) ? 4'b1011 : (p == 6) ? 4'b0111 : 4'hF;
                    settle_and_clear();
                    e = model(mode, sel);
                    rd(3'd5, d);
                    if (vmask != 4'hF && (mode != 2 || !vmask[sel])) tag = "R9 invalid input";
                    else if (mode == 1) tag = "R3 hottest rule R6";
                    else if (mode == 2) tag = "R4 selected rule R6";
                    else if (mode == 3) tag = "R5 reserved rule R6";
                    else tag = "R2 average rule R6";
                    check(d == {e, 29'b0}, tag, d, {e, 29'b0});
                    check(irq == |e, "R10 irq all enabled", {31'b0, irq}, {31'b0, |e});
                end
            end
        end

        // R6: equality boundary
        wr(3'd0, 32'h0);
        vmask = 4'hF;
        for (int k = 0; k < 4; k++) code[k] = 16'h2000;
        settle_and_clear();
        rd(3'd5, d);
        check(d == 32'h6000_0000, "R6 equal to threshold", d, 32'h6000_0000);
        for (int k = 0; k < 4; k++) code[k] = 16'h2001;
        settle_and_clear();
        rd(3'd5, d);
        check(d == 32'h2000_0000, "R6 one above threshold", d, 32'h2000_0000);

        // R7: sticky after the condition goes away
        for (int k = 0; k < 4; k++) code[k] = 16'h0100;
        settle_and_clear();
        for (int k = 0; k < 4; k++) code[k] = 16'h7000;
        idle(6);
        rd(3'd5, d);
        check(d == 32'hE000_0000, "R7 sticky", d, 32'hE000_0000);

        // R10: enables gate the interrupt
        wr(3'd4, 32'h0);
        check(irq == 1'b0, "R10 all disabled", {31'b0, irq}, 32'h0);
        wr(3'd4, 32'h2000_0000);
        check(irq == 1'b1, "R10 stage1 enabled", {31'b0, irq}, 32'h1);

        // R8: write-one-to-clear
        wr(3'd5, 32'h0);
        rd(3'd5, d);
        check(d == 32'hE000_0000, "R8 zeros leave bits", d, 32'hE000_0000);
        wr(3'd5, 32'h2000_0000);
        rd(3'd5, d);
        check(d == 32'hC000_0000, "R8 clear stage1", d, 32'hC000_0000);
        check(irq == 1'b0, "R10 enabled bit cleared", {31'b0, irq}, 32'h0);
        wr(3'd5, 32'h4000_0000);
        rd(3'd5, d);
        check(d == 32'h8000_0000, "R8 clear stage2", d, 32'h8000_0000);
        wr(3'd5, d);
        rd(3'd5, d);
        check(d == 32'h0, "R8 write back read value", d, 32'h0);

        summary();
    end

endmodule